// File: doc/BRIEF.md
# Programmable SRAM Strobe Timing Sequencer

This block runs one external static-memory bus cycle at a time. A caller presents a request with an area number, a direction, an address and write data. The sequencer drives the address and enables the data output for writes. It pulses the read or the write strobe for a single cycle, captures read data, and then signals completion with a one-cycle done pulse. Between address and strobe it can add one setup cycle. After the strobe it can add zero to three hold cycles.

Timing is set per area by a 28-bit configuration word that holds seven 4-bit fields, one per area. On areas 1 and 4, one extra bit decides when the read strobe is released. With that bit clear, the strobe stays asserted through the hold cycles. With it set, the strobe drops right after the sampling edge. Any area can be marked as byte-control memory through a mode input, and for such an area the early release is always disabled. The timing of an access is taken from the configuration when the request is accepted and does not change during that access.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset the configuration word is all zeros, `ready` is 1 and `bus_rd`, `bus_wr`, `bus_oe` and `done` are 0. An access to any area then has no setup cycle, one strobe cycle and no hold cycle, with `done` in the next cycle.
- R2: Area n (0..6) takes its timing from configuration bits [4n+3:4n]. Bit 4n+2 is the setup bit, bits [4n+1:4n] are the hold count and bit 4n+3 is the read-release bit. Area number 7 uses all-zero timing.
- R3: With the setup bit set, the first cycle after acceptance shows the address with both strobes low. For a write, `bus_oe` is already 1 in that cycle. The strobe follows in the next cycle.
- R4: The hold count h (0..3) adds h cycles after the strobe cycle. During these cycles `bus_addr` and `bus_wdata` are unchanged, `bus_wr` is 0 and, for a write, `bus_oe` stays 1.
- R5: The strobe cycle lasts exactly one cycle. Read data on `bus_rdata` is captured at the clock edge that ends the strobe cycle and is held on `rdata` afterwards.
- R6: For a read with an effective read-release bit of 0, `bus_rd` stays 1 through all hold cycles. With an effective bit of 1, `bus_rd` is 0 in the hold cycles.
- R7: The read-release bit takes effect only on areas 1 and 4. On other areas it is treated as 0.
- R8: When `area_bytectl[n]` is 1, the read-release bit of area n is treated as 0.
- R9: `done` is 1 for exactly one cycle, in the cycle after the last hold cycle (or after the strobe cycle when h is 0). `ready` is 1 in the cycle that follows.
- R10: A request is accepted only while `ready` is 1. Requests raised during an access are ignored and do not change the address, the direction or the timing of that access.
- R11: `bus_rd` and `bus_wr` are never 1 together. `bus_oe` is 1 only for writes, from the first cycle after acceptance through the last hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration word |
| cfg_wdata | input | 28 | New configuration word, 4 bits per area |
| area_bytectl | input | 7 | Per-area byte-control memory mode |
| req_valid | input | 1 | Request present |
| req_area | input | 3 | Area number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 32 | Write data |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured read data |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 32 | Memory write data |
| bus_rdata | input | 32 | Memory read data |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Write data output enable |

## Verification
A wrong state or a wrong hold count shows up at the ports within one cycle. The strobe or output enable comes out of the expected window, `done` arrives early or late, or `ready` does not return. A wrongly decoded area field or release bit changes the strobe pattern in the first cycle after acceptance or in the first hold cycle. A capture on the wrong edge is seen on `rdata` only at the end of the access, because the bench drives different data outside the strobe cycle.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic       rls_early;
        logic       setup;
        logic [1:0] hold;
    } area_timing_t;

endpackage

// File: rtl/sram_area_cfg.sv
module sram_area_cfg
    import sram_seq_pkg::*;
#(
    parameter int          NAREAS   = 7,
    parameter int          AREA_W   = 3,
    parameter logic [NAREAS-1:0] RLS_MASK = 7'b0010010,
    localparam int         CFG_W    = 4 * NAREAS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [NAREAS-1:0] bytectl,
    input  logic [AREA_W-1:0] sel,
    output area_timing_t      timing
);

    logic [CFG_W-1:0] cfg_d, cfg_q;
    area_timing_t     dec [NAREAS];
    logic             sel_bytectl;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) cfg_d = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar i = 0; i < NAREAS; i++) begin : g_area
        localparam bit CAN_RLS = RLS_MASK[i];
        always_comb begin
            dec[i].setup = cfg_q[4*i+2];
            dec[i].hold  = cfg_q[4*i +: 2];
            if (CAN_RLS) dec[i].rls_early = cfg_q[4*i+3] & ~bytectl[i];
            else         dec[i].rls_early = 1'b0;
        end
    end

    always_comb begin
        timing      = '0;
        sel_bytectl = 1'b0;
        for (int i = 0; i < NAREAS; i++) begin
            if (sel == AREA_W'(i)) begin
                timing      = dec[i];
                sel_bytectl = bytectl[i];
            end
        end
    end

    // R8
    bytectl_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_bytectl |-> !timing.rls_early);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  area_timing_t  timing,
    input  logic [DW-1:0] bus_rdata,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_oe
);

    typedef struct packed {
        seq_state_e    st;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [1:0]    hold;
        logic          rls_early;
        logic [DW-1:0] rdata;
    } seq_regs_t;

    seq_regs_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr        = req_write;
                    d.addr      = req_addr;
                    d.wdata     = req_wdata;
                    d.hold      = timing.hold;
                    d.rls_early = timing.rls_early;
                    d.st        = timing.setup ? ST_SETUP : ST_STROBE;
                end
            end
            ST_SETUP: d.st = ST_STROBE;
            ST_STROBE: begin
                if (!q.wr) d.rdata = bus_rdata;
                if (q.hold == 2'd0) d.st = ST_DONE;
                else begin
                    d.st   = ST_HOLD;
                    d.hold = q.hold - 2'd1;
                end
            end
            ST_HOLD: begin
                if (q.hold == 2'd0) d.st = ST_DONE;
                else                d.hold = q.hold - 2'd1;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic active;
    assign active    = (q.st == ST_SETUP) || (q.st == ST_STROBE) || (q.st == ST_HOLD);
    assign ready     = (q.st == ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign rdata     = q.rdata;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;
    assign bus_wr    = q.wr && (q.st == ST_STROBE);
    assign bus_rd    = !q.wr && ((q.st == ST_STROBE) || (q.st == ST_HOLD && !q.rls_early));
    assign bus_oe    = q.wr && active;

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R11
    oe_not_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !bus_rd);

    // R5
    wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && req_valid) |=> !ready || $past(q.st == ST_DONE));

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_seq_pkg::*;
#(
    parameter int NAREAS = 7,
    parameter int AREA_W = 3,
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter logic [NAREAS-1:0] RLS_MASK = 7'b0010010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [4*NAREAS-1:0] cfg_wdata,
    input  logic [NAREAS-1:0]   area_bytectl,
    input  logic                req_valid,
    input  logic [AREA_W-1:0]   req_area,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                ready,
    output logic                done,
    output logic [DW-1:0]       rdata,
    output logic [AW-1:0]       bus_addr,
    output logic [DW-1:0]       bus_wdata,
    input  logic [DW-1:0]       bus_rdata,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic                bus_oe
);

    area_timing_t sel_timing;

    sram_area_cfg #(
        .NAREAS   (NAREAS),
        .AREA_W   (AREA_W),
        .RLS_MASK (RLS_MASK)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .bytectl   (area_bytectl),
        .sel       (req_area),
        .timing    (sel_timing)
    );

    sram_seq_fsm #(
        .AW (AW),
        .DW (DW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .timing    (sel_timing),
        .bus_rdata (bus_rdata),
        .ready     (ready),
        .done      (done),
        .rdata     (rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_oe    (bus_oe)
    );

endmodule

// File: tb/sim_sram_strobe_seq.sv
`timescale 1ns/1ps
module sim_sram_strobe_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [27:0] cfg_wdata = '0;
    logic [6:0]  area_bytectl = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_area = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ready, done, bus_rd, bus_wr, bus_oe;
    logic [31:0] rdata, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [15:0] bus_addr;

    logic [27:0] cfg_m = '0;
    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    sram_strobe_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .area_bytectl(area_bytectl), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic load_cfg(input logic [27:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_m = v;
    endtask

    // One access, checked cycle by cycle against timing derived from the bench's copy of the configuration.
    task automatic do_access(input int a, input bit w, input logic [15:0] ad,
                             input logic [31:0] wd, input bit poke, input string tag);
        logic [3:0]  f;
        int          s, h, last;
        bit          early;
        logic [31:0] good, bad;
        f     = (a < 7) ? cfg_m[4*a +: 4] : 4'h0;
        s     = int'(f[2]);
        h     = int'(f[1:0]);
        early = f[3] && (a == 1 || a == 4) && !area_bytectl[a % 7];
        last  = s + 2 + h;
        good  = 32'hA5C30000 ^ {16'h0, ad};
        bad   = ~good;
        @(negedge clk);
        req_valid = 1'b1; req_area = 3'(a); req_write = w;
        req_addr = ad; req_wdata = wd; bus_rdata = bad;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= last; k++) begin
            logic xrd, xwr, xoe, xdone;
            if (poke && k == 1) begin
                req_valid = 1'b1; req_addr = ~ad; req_write = ~w; req_area = 3'd6;
            end
            if (poke && k == 2) req_valid = 1'b0;
            xrd   = !w && ((k == s + 1) || (k > s + 1 && k <= s + 1 + h && !early));
            xwr   = w && (k == s + 1);
            xoe   = w && (k <= s + 1 + h);
            xdone = (k == last);
            chk(tag, $sformatf("strobes cycle %0d", k),
                64'({bus_rd, bus_wr, bus_oe, done, ready}),
                64'({xrd, xwr, xoe, xdone, 1'b0}));
            if (k <= s + 1 + h) begin
                chk(tag, $sformatf("addr cycle %0d", k), 64'(bus_addr), 64'(ad));
                if (w) chk(tag, $sformatf("wdata cycle %0d", k), 64'(bus_wdata), 64'(wd));
            end
            bus_rdata = (k == s + 1) ? good : bad;
            @(posedge clk);
            @(negedge clk);
        end
        chk(tag, "return to ready", 64'({bus_rd, bus_wr, bus_oe, done, ready}), 64'(5'b00001));
        if (!w) chk(tag, "captured rdata", 64'(rdata), 64'(good));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "reset outputs", 64'({bus_rd, bus_wr, bus_oe, done, ready}), 64'(5'b00001));
        do_access(3, 1'b0, 16'h1234, 32'h0, 1'b0, "R1");
        do_access(5, 1'b1, 16'h4321, 32'hDEADBEEF, 1'b0, "R1");
    endtask

    task automatic t_fields;
        // area6..area0 = F, A, D, 7, 1, B, 6
        load_cfg({4'hF, 4'hA, 4'hD, 4'h7, 4'h1, 4'hB, 4'h6});
        do_access(0, 1'b1, 16'h0A00, 32'h11112222, 1'b0, "R3");
        do_access(0, 1'b0, 16'h0A01, 32'h0, 1'b0, "R3");
        do_access(2, 1'b1, 16'h0A02, 32'h33334444, 1'b0, "R4");
        do_access(3, 1'b1, 16'h0A03, 32'h55556666, 1'b0, "R11");
        do_access(3, 1'b0, 16'h0A13, 32'h0, 1'b0, "R4");
        do_access(6, 1'b0, 16'h0A06, 32'h0, 1'b0, "R5");
        do_access(7, 1'b0, 16'h0A07, 32'h0, 1'b0, "R2");
        do_access(2, 1'b0, 16'h0A12, 32'h0, 1'b0, "R9");
    endtask

    task automatic t_release;
        do_access(1, 1'b0, 16'h0B01, 32'h0, 1'b0, "R6");
        do_access(4, 1'b0, 16'h0B04, 32'h0, 1'b0, "R6");
        do_access(5, 1'b0, 16'h0B05, 32'h0, 1'b0, "R7");
        do_access(6, 1'b0, 16'h0B16, 32'h0, 1'b0, "R7");
    endtask

    task automatic t_bytectl;
        area_bytectl = 7'b0010010;
        do_access(1, 1'b0, 16'h0C01, 32'h0, 1'b0, "R8");
        do_access(4, 1'b0, 16'h0C04, 32'h0, 1'b0, "R8");
        area_bytectl = '0;
        do_access(4, 1'b0, 16'h0C14, 32'h0, 1'b0, "R6");
    endtask

    task automatic t_busy;
        do_access(0, 1'b1, 16'h0D00, 32'h77778888, 1'b1, "R10");
        do_access(3, 1'b0, 16'h0D03, 32'h0, 1'b1, "R10");
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_release();
        t_bytectl();
        t_busy();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule